// File: doc/BRIEF.md
# SPI Master with Programmable Burst Length

This block is a mode-0 SPI master. It takes transmit words from a 32-bit stream into a transmit FIFO and returns received words on a 32-bit stream from a receive FIFO. The burst is the number of bits shifted while the single chip select stays low. It is set by a register and has no tie to the FIFO word size. One burst can therefore be a few bits cut from one word, or a long run that draws many words in turn.

Software sets up the block through a small register bus. The bus holds:
- the start mode, which is either automatic or on command;
- the burst length;
- the clock divider;
- a command register;
- a status register.

The status register has a sticky completion flag and a busy flag. Both change only after the hold period that follows the last SCLK edge, so the completion flag marks the moment the line is really idle. It is not tied to the transmit FIFO running empty.

Both data streams use valid/ready. A transmit word is accepted only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the transmit FIFO is full. A received word stays on `rx_data` with `rx_valid` high until `rx_ready` accepts it. When the receive FIFO is full, a newly assembled word is dropped and flagged, and the line does not stall.

Top module: `spi_burst_master`

## Requirements
- R1: With MODE (address 0) bit 0 set, a burst starts as soon as the transmit FIFO holds a word. With it clear, no burst starts until 1 is written to CMD (address 3) bit 0. That request is then held until a burst starts.
- R2: LEN (address 1) bits 11:0 hold the burst length minus one, which gives 1 to 4096 bits. One burst gives exactly that many SCLK rising edges, and chip select stays low for the whole burst.
- R3: MOSI sends bits MSB first. The first word of a burst gives its low-order (length mod 32) bits, or all 32 bits when that remainder is 0. Every later word gives all 32 bits, so an 8-bit burst uses only bits 7:0 of its word.
- R4: SCLK idles low, and its period is 2×(DIV+1) system clocks, where DIV is at address 2, bits 11:0. Chip select falls one SCLK period before the first rising edge. It rises one SCLK period after the last falling edge.
- R5: STAT (address 4) bit 0 is set in the cycle chip select rises at the end of a burst. It stays set until 1 is written to STAT bit 0.
- R6: STAT bit 1 (busy) is 1 while a command request is pending or a burst is running. It returns to 0 only when chip select rises.
- R7: If the transmit FIFO is empty when a burst needs its next word, SCLK holds low and chip select stays low. The flag in R5 stays clear and busy stays set until a word arrives.
- R8: Received bits are packed the same way as transmit bits, with the first word holding the remainder bits at its low end. Words come out in order on the rx stream and are held while `rx_ready` is low.
- R9: A received word that finds the receive FIFO full is dropped, and STAT bit 2 is set. That bit is cleared by writing 1 to it.
- R10: `tx_ready` is low while the transmit FIFO holds TX_DEPTH words.
- R11: After reset:
  - chip select is high and SCLK is low;
  - STAT reads 0;
  - `tx_ready` is 1 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data for reg_addr (combinational) |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit FIFO can accept a word |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 32 | Received word |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The timing rules are as follows:
- Chip select falls on the clock edge after a start condition.
- The first SCLK rise comes 2×(DIV+1) cycles after chip select falls.
- Later rises are spaced 2×(DIV+1) cycles apart.
- Chip select rises 2×(DIV+1) cycles after the last fall.
- The done and busy changes land in that same cycle.

The bench watches the pins on the falling clock edge and timestamps each SCLK and chip-select transition with a cycle counter. It then compares the gaps with those figures rather than checking at fixed times. A received word appears on the rx stream one cycle after the rising-edge phase of its last bit. The bench takes received words when valid and ready are both high, and compares them only after the completion flag is seen, which is at least one SCLK period later. Status reads are combinational, so the bench polls each cycle and also checks that chip select is already high when the flag first shows.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_WAIT, ST_TAIL
  } sbm_phase_e;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_LEN  = 3'd1;
  localparam logic [2:0] A_DIV  = 3'd2;
  localparam logic [2:0] A_CMD  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
endpackage

// File: rtl/sbm_fifo.sv
`timescale 1ns/1ps
module sbm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push, pop;

  assign in_ready  = (cnt != (AW+1)'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end
endmodule

// File: rtl/sbm_engine.sv
`timescale 1ns/1ps
module sbm_engine
  import sbm_pkg::*;
#(
  parameter int W    = 32,
  parameter int LENW = 12,
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ok,
  input  logic [LENW-1:0] len_m1,
  input  logic [DIVW-1:0] div,
  input  logic            word_valid,
  output logic            word_take,
  input  logic [W-1:0]    word,
  output logic            rx_push,
  output logic [W-1:0]    rx_word,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi,
  input  logic            miso,
  output logic            active,
  output logic            burst_end
);
  localparam int SW  = $clog2(W);
  localparam int CW  = SW + 1;
  localparam int BLW = LENW + 1;

  sbm_phase_e      st;
  logic [DIVW-1:0] dcnt;
  logic            tick, half, start, last_bit, word_done;
  logic [W-1:0]    txsr, rxsr;
  logic [CW-1:0]   wbits, first_bits;
  logic [BLW-1:0]  left, len;
  logic [SW-1:0]   rem;

  assign len        = {1'b0, len_m1} + BLW'(1);
  assign rem        = len[SW-1:0];
  assign first_bits = (rem == '0) ? CW'(W) : CW'(rem);
  assign tick       = (dcnt == div);
  assign start      = (st == ST_IDLE) && start_ok && word_valid;
  assign last_bit   = (left == BLW'(1));
  assign word_done  = (wbits == CW'(1));

  assign word_take = start
                   | ((st == ST_HIGH) && tick && !last_bit && word_done && word_valid)
                   | ((st == ST_WAIT) && word_valid);
  assign rx_push   = (st == ST_HIGH) && tick && word_done;
  assign rx_word   = rxsr;
  assign burst_end = (st == ST_TAIL) && tick && half;
  assign active    = (st != ST_IDLE);
  assign sclk      = (st == ST_HIGH);
  assign cs_n      = (st == ST_IDLE);
  assign mosi      = active & txsr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      dcnt  <= '0;
      half  <= 1'b0;
      txsr  <= '0;
      rxsr  <= '0;
      wbits <= '0;
      left  <= '0;
    end else begin
      if (st == ST_IDLE || st == ST_WAIT || tick) dcnt <= '0;
      else                                        dcnt <= dcnt + 1'b1;
      unique case (st)
        ST_IDLE: if (start) begin
          st    <= ST_LEAD;
          half  <= 1'b0;
          txsr  <= word << (CW'(W) - first_bits);
          wbits <= first_bits;
          left  <= len;
          rxsr  <= '0;
        end
        ST_LEAD: if (tick) begin
          if (half) begin
            st   <= ST_HIGH;
            half <= 1'b0;
            rxsr <= {rxsr[W-2:0], miso};
          end else half <= 1'b1;
        end
        ST_HIGH: if (tick) begin
          left <= left - 1'b1;
          if (last_bit) st <= ST_TAIL;
          else if (word_done) begin
            rxsr <= '0;
            if (word_valid) begin
              txsr  <= word;
              wbits <= CW'(W);
              st    <= ST_LOW;
            end else st <= ST_WAIT;
          end else begin
            txsr  <= txsr << 1;
            wbits <= wbits - 1'b1;
            st    <= ST_LOW;
          end
        end
        ST_LOW: if (tick) begin
          st   <= ST_HIGH;
          rxsr <= {rxsr[W-2:0], miso};
        end
        ST_WAIT: if (word_valid) begin
          txsr  <= word;
          wbits <= CW'(W);
          st    <= ST_LOW;
        end
        ST_TAIL: if (tick) begin
          if (half) begin
            st   <= ST_IDLE;
            half <= 1'b0;
          end else half <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
  import sbm_pkg::*;
#(
  parameter int W        = 32,
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 16,
  parameter int LENW     = 12,
  parameter int DIVW     = 12,
  localparam int RW      = (LENW > DIVW) ? LENW : DIVW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [W-1:0]  tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [W-1:0]  rx_data,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  logic            mode_auto, go_pend, done_q, ovf_q, busy;
  logic [LENW-1:0] len_m1;
  logic [DIVW-1:0] div_q;
  logic            word_valid, word_take, rx_push, rx_in_ready, rx_fifo_full;
  logic            active, burst_end, start_ok, start_ev;
  logic [W-1:0]    word, rx_word;

  assign start_ok     = mode_auto | go_pend;
  assign start_ev     = word_take & ~active;
  assign busy         = active | go_pend;
  assign rx_fifo_full = ~rx_in_ready;

  sbm_fifo #(.W(W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(word_valid), .out_ready(word_take), .out_data(word)
  );

  sbm_fifo #(.W(W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_in_ready), .in_data(rx_word),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  sbm_engine #(.W(W), .LENW(LENW), .DIVW(DIVW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .len_m1(len_m1), .div(div_q),
    .word_valid(word_valid), .word_take(word_take), .word(word),
    .rx_push(rx_push), .rx_word(rx_word),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
    .active(active), .burst_end(burst_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_auto <= 1'b0;
      len_m1    <= '0;
      div_q     <= '0;
      go_pend   <= 1'b0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MODE) mode_auto <= reg_wdata[0];
      if (reg_wr && reg_addr == A_LEN)  len_m1    <= reg_wdata[LENW-1:0];
      if (reg_wr && reg_addr == A_DIV)  div_q     <= reg_wdata[DIVW-1:0];
      if (start_ev) go_pend <= 1'b0;
      else if (reg_wr && reg_addr == A_CMD && reg_wdata[0]) go_pend <= 1'b1;
      if (burst_end) done_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[0]) done_q <= 1'b0;
      if (rx_push && !rx_in_ready) ovf_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[2]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_MODE:  reg_rdata = RW'(mode_auto);
      A_LEN:   reg_rdata = RW'(len_m1);
      A_DIV:   reg_rdata = RW'(div_q);
      A_STAT:  reg_rdata = RW'({ovf_q, busy, done_q});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sbm_checker.sv
`timescale 1ns/1ps
module sbm_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic done_flag,
  input logic busy_flag,
  input logic ovf_flag,
  input logic rx_fifo_full,
  input logic start_ok
);
  a_r1_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start_ok));

  a_r4_cs_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(!cs_n));

  a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r5_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $rose(cs_n));

  a_r6_busy_ends_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_flag) |-> $rose(cs_n));

  a_r9_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(rx_fifo_full));
endmodule

bind spi_burst_master sbm_checker u_sbm_checker (
  .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
  .done_flag(done_q), .busy_flag(busy), .ovf_flag(ovf_q),
  .rx_fifo_full(rx_fifo_full), .start_ok(start_ok)
);

// File: tb/test_spi_burst_master.sv
`timescale 1ns/1ps
module test_spi_burst_master;
  localparam logic [2:0] A_MODE = 3'd0, A_LEN = 3'd1, A_DIV = 3'd2, A_CMD = 3'd3, A_STAT = 3'd4;
  // {length 13b, divider 8b, seed 32b}
  localparam logic [52:0] VECS [0:5] = '{
    {13'd8,  8'd0, 32'hA5C3_1E7F},
    {13'd1,  8'd1, 32'h0000_0001},
    {13'd32, 8'd0, 32'h1234_5678},
    {13'd45, 8'd2, 32'hDEAD_BEEF},
    {13'd96, 8'd1, 32'h0F1E_2D3C},
    {13'd70, 8'd3, 32'h8001_7FFE}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b1;
  logic [31:0] tx_data = '0, rx_data;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso = 1'b0;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic cap [0:4095];
  int k_rise = 0, t_csfall = 0, t_first = 0, t_second = 0, t_lastfall = 0, t_csrise = 0;
  logic sclk_p = 1'b0, cs_p = 1'b1;
  logic [31:0] mseed = '0;
  logic [31:0] rxbuf [0:255];
  int rx_n = 0;

  function automatic logic [31:0] word_of(logic [31:0] s, int j);
    return (s + 32'(j) * 32'h9E37_79B9) ^ {s[15:0], s[31:16]};
  endfunction

  function automatic logic miso_bit(int k, logic [31:0] s);
    return s[k % 32] ^ ((k / 32) % 2 == 1);
  endfunction

  function automatic int rem_of(int len);
    return (len % 32 == 0) ? 32 : len % 32;
  endfunction

  function automatic logic exp_mosi(int k, int len, logic [31:0] s);
    int r = rem_of(len);
    logic [31:0] w;
    if (k < r) begin
      w = word_of(s, 0);
      return w[r - 1 - k];
    end
    w = word_of(s, 1 + (k - r) / 32);
    return w[31 - ((k - r) % 32)];
  endfunction

  function automatic logic [31:0] exp_rx(int len, int wi, logic [31:0] ms);
    int r = rem_of(len);
    int lo = (wi == 0) ? 0 : r + (wi - 1) * 32;
    int hi = (wi == 0) ? r : lo + 32;
    logic [31:0] e = '0;
    for (int k = lo; k < hi; k++) e = {e[30:0], miso_bit(k, ms)};
    return e;
  endfunction

  // pin monitor and mode-0 slave model, evaluated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cs_p && !spi_cs_n) begin
      k_rise = 0; t_csfall = cyc; spi_miso = miso_bit(0, mseed);
    end
    if (!sclk_p && spi_sclk) begin
      cap[k_rise % 4096] = spi_mosi;
      if (k_rise == 0) t_first = cyc;
      if (k_rise == 1) t_second = cyc;
      k_rise++;
    end
    if (sclk_p && !spi_sclk) begin
      t_lastfall = cyc; spi_miso = miso_bit(k_rise, mseed);
    end
    if (!cs_p && spi_cs_n) t_csrise = cyc;
    sclk_p = spi_sclk;
    cs_p   = spi_cs_n;
  end

  always @(posedge clk) begin
    if (rx_valid && rx_ready) begin
      rxbuf[rx_n % 256] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [11:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [11:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  // polls STAT each cycle; when done first shows, the line must already be released
  task automatic wait_done();
    logic [11:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, s);
      if (s[0]) begin
        chk(spi_cs_n == 1'b1, "R5", "cs high when done seen", spi_cs_n, 1);
        chk(s[1] == 1'b0, "R6", "busy clear when done seen", s[1], 0);
        return;
      end
    end
    chk(0, "R5", "done never set", 0, 1);
  endtask

  task automatic check_burst(int len, int div, logic [31:0] seed, int base);
    int bad = 0, nw = (len + 31) / 32, per = 2 * (div + 1);
    chk(k_rise == len, "R2", "rising edges", k_rise, len);
    for (int k = 0; k < len; k++) if (cap[k] !== exp_mosi(k, len, seed)) bad++;
    chk(bad == 0, "R3", "mosi bit errors", bad, 0);
    chk(rx_n - base == nw, "R8", "rx word count", rx_n - base, nw);
    for (int w = 0; w < nw; w++)
      chk(rxbuf[(base + w) % 256] == exp_rx(len, w, seed ^ 32'h5A5A_0F0F), "R8", "rx word",
          rxbuf[(base + w) % 256], exp_rx(len, w, seed ^ 32'h5A5A_0F0F));
    chk(t_first - t_csfall == per, "R4", "cs lead", t_first - t_csfall, per);
    chk(t_csrise - t_lastfall == per, "R4", "cs tail", t_csrise - t_lastfall, per);
    if (len > 1) chk(t_second - t_first == per, "R4", "sclk period", t_second - t_first, per);
  endtask

  initial begin
    logic [11:0] s;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(A_STAT, s);
    chk(s == 12'd0, "R11", "STAT after reset", s, 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11", "pins idle", {spi_cs_n, spi_sclk}, 2);
    chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R11", "streams idle", {tx_ready, rx_valid}, 2);

    // table of bursts in automatic mode (R1, R2, R3, R4, R5, R6, R8)
    for (int v = 0; v < 6; v++) begin
      int len = int'(VECS[v][52:40]);
      int dv  = int'(VECS[v][39:32]);
      logic [31:0] sd = VECS[v][31:0];
      wr(A_LEN, 12'(len - 1)); wr(A_DIV, 12'(dv)); wr(A_MODE, 12'd1);
      mseed = sd ^ 32'h5A5A_0F0F;
      base = rx_n;
      for (int j = 0; j < (len + 31) / 32; j++) push(word_of(sd, j));
      wait_done();
      check_burst(len, dv, sd, base);
      rd(A_STAT, s);
      chk(s[0] == 1'b1, "R5", "done sticky", s[0], 1);
      wr(A_STAT, 12'd1);
      rd(A_STAT, s);
      chk(s[0] == 1'b0, "R5", "done cleared by W1C", s[0], 0);
    end

    // R1 command mode
    wr(A_MODE, 12'd0); wr(A_LEN, 12'd15); wr(A_DIV, 12'd0);
    mseed = 32'h0BAD_F00D ^ 32'h5A5A_0F0F;
    base = rx_n;
    push(word_of(32'h0BAD_F00D, 0));
    repeat (40) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "no start without command", spi_cs_n, 1);
    rd(A_STAT, s);
    chk(s[1] == 1'b0, "R1", "idle busy without command", s[1], 0);
    wr(A_CMD, 12'd1);
    wait_done();
    check_burst(16, 0, 32'h0BAD_F00D, base);
    wr(A_STAT, 12'd1);

    // R7 stall on empty FIFO mid-burst
    wr(A_MODE, 12'd1); wr(A_LEN, 12'd63); wr(A_DIV, 12'd1);
    mseed = 32'h7777_1111 ^ 32'h5A5A_0F0F;
    base = rx_n;
    push(word_of(32'h7777_1111, 0));
    repeat (200) @(negedge clk);
    chk(spi_cs_n == 1'b0 && spi_sclk == 1'b0, "R7", "stalled pins", {spi_cs_n, spi_sclk}, 0);
    chk(k_rise == 32, "R7", "edges before stall", k_rise, 32);
    rd(A_STAT, s);
    chk(s[1:0] == 2'b10, "R7", "busy set, done clear", s[1:0], 2);
    push(word_of(32'h7777_1111, 1));
    wait_done();
    check_burst(64, 1, 32'h7777_1111, base);
    wr(A_STAT, 12'd1);

    // R9 overflow with R8 back-pressure
    rx_ready = 1'b0;
    wr(A_LEN, 12'd543); wr(A_DIV, 12'd0);
    mseed = 32'hC0DE_0042 ^ 32'h5A5A_0F0F;
    base = rx_n;
    for (int j = 0; j < 17; j++) push(word_of(32'hC0DE_0042, j));
    wait_done();
    chk(k_rise == 544, "R2", "long burst edges", k_rise, 544);
    rd(A_STAT, s);
    chk(s[2] == 1'b1, "R9", "overflow flag", s[2], 1);
    chk(rx_valid == 1'b1 && rx_n == base, "R8", "word held under back-pressure", rx_n - base, 0);
    @(negedge clk); rx_ready = 1'b1;
    repeat (30) @(negedge clk);
    chk(rx_n - base == 16, "R9", "words kept", rx_n - base, 16);
    for (int w = 0; w < 16; w++)
      chk(rxbuf[(base + w) % 256] == exp_rx(544, w, mseed), "R9", "kept word",
          rxbuf[(base + w) % 256], exp_rx(544, w, mseed));
    wr(A_STAT, 12'd5);
    rd(A_STAT, s);
    chk(s[2:0] == 3'b000, "R9", "flags cleared by W1C", s[2:0], 0);

    // R10 transmit FIFO full, then drain with one 2048-bit burst
    wr(A_MODE, 12'd0); wr(A_LEN, 12'd2047); wr(A_DIV, 12'd0);
    mseed = 32'h3141_5926 ^ 32'h5A5A_0F0F;
    base = rx_n;
    for (int j = 0; j < 64; j++) push(word_of(32'h3141_5926, j));
    @(negedge clk);
    chk(tx_ready == 1'b0, "R10", "tx_ready when full", tx_ready, 0);
    wr(A_CMD, 12'd1);
    wait_done();
    check_burst(2048, 0, 32'h3141_5926, base);

    summary();
  end
endmodule